// File: doc/BRIEF.md
# DS3 Frame Timing Enable Generator

This block follows the bit position inside a 4760-bit DS3 M-frame while running from a continuous bit clock with no gaps. On every clock it reports whether the current bit carries payload or overhead. The bit clock itself never stops, so the enable output is the only marker of the overhead slots. It also raises a one-clock marker a programmable number of bits before the M1 overhead bit. Downstream logic can use that marker to find the frame phase.

The frame has 7 subframes of 680 bits. Each subframe has 8 blocks of 85 bits, and the first bit of every block is overhead. That gives 56 overhead bits per frame. The subframe leaders run X1, X2, P1, P2, M1, M2, M3, so M1 sits at bit index 2720.

The frame phase is not fixed by reset. A frame-load input restarts the count at index 0, which lets a caller line the block up with an M1 that arrives at any time. Each direction of a link uses its own instance.

Top module: `ds3_frame_gate`

## Requirements
- R1: The bit index advances by exactly one on every clock that has neither reset nor frame load. After reset is released, the first overhead slot at or after index 1 appears exactly 85 clocks later.
- R2: The frame is 4760 bits long. The index wraps from 4759 to 0, so sync markers with the same lead are exactly 4760 clocks apart.
- R3: `payload_en` is 0 on every index i with i mod 85 == 0 and 1 on every other index. This gives 56 low bits per frame.
- R4: M1 is at index 2720, the first bit of subframe 4 when subframes are counted from 0. With a lead of 0, the marker falls on the M1 bit itself.
- R5: With `sync_on` = 1, `frame_mark` is high for exactly one clock per frame, at index (2720 − lead) mod 4760. Leads from 0 to 255 are all accepted.
- R6: While `sync_on` is 0, `frame_mark` stays 0 through whole frames.
- R7: When `frame_load` is 1 at a clock edge, the index is 0 after that edge. The count then continues from there, and the next marker comes 2720 − lead clocks later.
- R8: The lead is taken from `sync_lead` only at a frame wrap, at a frame load, or while reset is held. A change in the middle of a frame takes effect only from the next frame.
- R9: While `rst` is 1, the index is held at 0 and both `payload_en` and `frame_mark` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous bit clock, one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| frame_load | input | 1 | Forces the bit index to 0 at the next edge |
| sync_on | input | 1 | Enables the sync marker |
| sync_lead | input | 8 | Number of bits the marker leads M1 |
| payload_en | output | 1 | 1 on payload bits, 0 on overhead bits |
| frame_mark | output | 1 | One-clock marker ahead of M1 |

## Verification
The bench first lets the count run freely from reset with a lead of 0. This separates a correct overhead spacing from a wrong block length and shows whether the marker sits on M1 itself. It then changes the lead in the middle of a frame, which tells a lead applied at the frame edge apart from one applied at once. Next it switches the marker off for more than a frame, then pulses frame load at arbitrary points. A final run with the largest lead, 255, probes the far end of the lead range. A behavioural model of the index compares both outputs on every clock.

// File: rtl/ds3fg_pkg.sv
package ds3fg_pkg;

  localparam int DEF_BLOCK_BITS     = 85;
  localparam int DEF_BLOCKS_PER_SUB = 8;
  localparam int DEF_SUBS           = 7;
  localparam int DEF_M1_SUB         = 4;

  // index of the first bit of a given subframe
  function automatic int m1_index(input int block_bits, input int blocks, input int sub);
    return sub * blocks * block_bits;
  endfunction

  // position of the sync marker: lead bits ahead of m1, wrapped into one frame
  function automatic int sync_slot(input int frame_bits, input int m1_pos, input int lead);
    int back;
    back = lead % frame_bits;
    return (m1_pos >= back) ? (m1_pos - back) : (m1_pos + frame_bits - back);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ds3fg_bitpos.sv
module ds3fg_bitpos #(
  parameter int FRAME_BITS = 4760,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_load,
  output logic [POS_W-1:0] pos,
  output logic             pos_last
);

  assign pos_last = (pos == POS_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (frame_load || pos_last)
      pos <= '0;
    else
      pos <= pos + POS_W'(1);
  end

endmodule

// File: rtl/ds3fg_ohdec.sv
module ds3fg_ohdec #(
  parameter int BLOCK_BITS     = 85,
  parameter int BLOCKS_PER_SUB = 8,
  parameter int SUBS           = 7,
  parameter int M1_SUB         = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic oh_bit,
  output logic m1_bit
);

  localparam int LEVELS = 3;
  localparam int CW     = $clog2(ds3fg_pkg::max3(BLOCK_BITS, BLOCKS_PER_SUB, SUBS) + 1);

  function automatic int lvl_limit(input int g);
    case (g)
      0:       return BLOCK_BITS;
      1:       return BLOCKS_PER_SUB;
      default: return SUBS;
    endcase
  endfunction

  logic [CW-1:0]   cnt [LEVELS];
  logic [LEVELS:0] carry;

  assign carry[0] = 1'b1;

  // bit-in-block, block-in-subframe and subframe counters, cascaded by carry
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int LIM = lvl_limit(g);
    logic at_top;
    assign at_top       = (cnt[g] == CW'(LIM - 1));
    assign carry[g + 1] = carry[g] && at_top;

    always_ff @(posedge clk) begin
      if (rst || restart)
        cnt[g] <= '0;
      else if (carry[g])
        cnt[g] <= at_top ? '0 : cnt[g] + CW'(1);
    end
  end

  assign oh_bit = (cnt[0] == '0);
  assign m1_bit = oh_bit && (cnt[1] == '0) && (cnt[2] == CW'(M1_SUB));

endmodule

// File: rtl/ds3fg_syncpos.sv
module ds3fg_syncpos #(
  parameter int FRAME_BITS = 4760,
  parameter int POS_W      = $clog2(FRAME_BITS),
  parameter int LEAD_W     = 8,
  parameter int M1_POS     = 2720
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LEAD_W-1:0] sync_lead,
  input  logic [POS_W-1:0]  pos,
  output logic              hit
);

  logic [LEAD_W-1:0] lead_q;
  logic [POS_W-1:0]  slot;

  // lead held for a whole frame; refreshed only at frame edges
  always_ff @(posedge clk) begin
    if (rst || capture)
      lead_q <= sync_lead;
  end

  assign slot = POS_W'(ds3fg_pkg::sync_slot(FRAME_BITS, M1_POS, int'(lead_q)));
  assign hit  = (pos == slot);

endmodule

// File: rtl/ds3_frame_gate.sv
module ds3_frame_gate #(
  parameter int BLOCK_BITS     = ds3fg_pkg::DEF_BLOCK_BITS,
  parameter int BLOCKS_PER_SUB = ds3fg_pkg::DEF_BLOCKS_PER_SUB,
  parameter int SUBS           = ds3fg_pkg::DEF_SUBS,
  parameter int M1_SUB         = ds3fg_pkg::DEF_M1_SUB,
  parameter int LEAD_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_load,
  input  logic              sync_on,
  input  logic [LEAD_W-1:0] sync_lead,
  output logic              payload_en,
  output logic              frame_mark
);

  localparam int FRAME_BITS = BLOCK_BITS * BLOCKS_PER_SUB * SUBS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int M1_POS     = ds3fg_pkg::m1_index(BLOCK_BITS, BLOCKS_PER_SUB, M1_SUB);

  logic [POS_W-1:0] pos;
  logic             pos_last;
  logic             oh_bit;
  logic             m1_bit;
  logic             slot_hit;
  logic             lead_capture;

  ds3fg_bitpos #(
    .FRAME_BITS(FRAME_BITS),
    .POS_W     (POS_W)
  ) u_bitpos (
    .clk       (clk),
    .rst       (rst),
    .frame_load(frame_load),
    .pos       (pos),
    .pos_last  (pos_last)
  );

  ds3fg_ohdec #(
    .BLOCK_BITS    (BLOCK_BITS),
    .BLOCKS_PER_SUB(BLOCKS_PER_SUB),
    .SUBS          (SUBS),
    .M1_SUB        (M1_SUB)
  ) u_ohdec (
    .clk    (clk),
    .rst    (rst),
    .restart(frame_load),
    .oh_bit (oh_bit),
    .m1_bit (m1_bit)
  );

  assign lead_capture = frame_load || pos_last;

  ds3fg_syncpos #(
    .FRAME_BITS(FRAME_BITS),
    .POS_W     (POS_W),
    .LEAD_W    (LEAD_W),
    .M1_POS    (M1_POS)
  ) u_syncpos (
    .clk      (clk),
    .rst      (rst),
    .capture  (lead_capture),
    .sync_lead(sync_lead),
    .pos      (pos),
    .hit      (slot_hit)
  );

  assign payload_en = !rst && !oh_bit;
  assign frame_mark = !rst && sync_on && slot_hit;

endmodule

// File: rtl/ds3fg_chk.sv
module ds3fg_chk #(
  parameter int FRAME_BITS = 4760,
  parameter int POS_W      = 13,
  parameter int M1_POS     = 2720
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_load,
  input logic             sync_on,
  input logic             payload_en,
  input logic             frame_mark,
  input logic [POS_W-1:0] pos,
  input logic             pos_last,
  input logic             oh_bit,
  input logic             m1_bit
);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos < POS_W'(FRAME_BITS));                                          // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pos_last && !frame_load) |=> (pos == '0));                         // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!pos_last && !frame_load) |=> (pos == $past(pos) + POS_W'(1)));    // R1
  AST_FRAME_START_OH: assert property (@(posedge clk) disable iff (rst)
    (pos == '0) |-> (oh_bit && !payload_en));                           // R3
  AST_M1_INDEX: assert property (@(posedge clk) disable iff (rst)
    m1_bit |-> (pos == POS_W'(M1_POS)));                                // R4
  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_mark |=> !frame_mark);                                        // R5
  AST_MARK_OFF: assert property (@(posedge clk) disable iff (rst)
    !sync_on |-> !frame_mark);                                          // R6
  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_load |=> (pos == '0 && oh_bit));                              // R7
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |-> (!payload_en && !frame_mark));                              // R9

endmodule

bind ds3_frame_gate ds3fg_chk #(
  .FRAME_BITS(FRAME_BITS),
  .POS_W     (POS_W),
  .M1_POS    (M1_POS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_load(frame_load),
  .sync_on   (sync_on),
  .payload_en(payload_en),
  .frame_mark(frame_mark),
  .pos       (pos),
  .pos_last  (pos_last),
  .oh_bit    (oh_bit),
  .m1_bit    (m1_bit)
);

// File: tb/ds3_frame_gate_bench.sv
module ds3_frame_gate_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_load = 1'b0;
  logic       sync_on = 1'b1;
  logic [7:0] sync_lead = 8'd0;
  logic       payload_en;
  logic       frame_mark;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rel    = -100000;
  int mpos   = 0;
  int mlead  = 0;
  int oh_cnt = 0;
  int first_low = -1;
  int fm_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  ds3_frame_gate u_ds3_frame_gate (
    .clk       (clk),
    .rst       (rst),
    .frame_load(frame_load),
    .sync_on   (sync_on),
    .sync_lead (sync_lead),
    .payload_en(payload_en),
    .frame_mark(frame_mark)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // behavioural reference: frame index and lead in force for the frame
  always @(posedge clk) begin
    if (rst) begin
      mpos  = 0;
      mlead = int'(sync_lead);
    end else if (frame_load || mpos == 4759) begin
      mpos  = 0;
      mlead = int'(sync_lead);
    end else begin
      mpos++;
    end
  end

  always @(negedge clk) begin
    bit exp_pe, exp_fm;
    cyc++;
    rel++;
    exp_pe = !rst && (mpos % 85 != 0);
    exp_fm = !rst && sync_on && (mpos == (2720 - mlead + 4760) % 4760);
    check(payload_en == exp_pe, $sformatf("R3 payload_en at index %0d", mpos), payload_en, exp_pe);
    check(frame_mark == exp_fm, $sformatf("R5 frame_mark at index %0d", mpos), frame_mark, exp_fm);
    if (!payload_en && rel >= 1 && rel <= 4760) begin
      oh_cnt++;
      if (first_low < 0) first_low = rel;
    end
    if (frame_mark) fm_q.push_back(rel);
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired got %0d expected %0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_rel(input int r);
    do @(posedge clk); while (rel < r);
    #2;
  endtask

  task automatic pulse_load(output int zero_rel);
    frame_load = 1'b1;
    zero_rel = rel + 2;
    @(posedge clk);
    #2;
    frame_load = 1'b0;
  endtask

  initial begin
    int l1, l2, nq;
    repeat (3) @(posedge clk);
    #2;
    check(payload_en == 1'b0, "R9 payload_en in reset", payload_en, 0);
    check(frame_mark == 1'b0, "R9 frame_mark in reset", frame_mark, 0);
    rst = 1'b0;
    rel = -1;

    wait_rel(5760);
    sync_lead = 8'd200;              // mid-frame change
    wait_rel(13000);
    check(first_low == 85, "R1 first overhead after release", first_low, 85);
    check(oh_cnt == 56, "R3 overhead bits in one frame", oh_cnt, 56);
    check(fm_q.size() == 3, "R5 markers in three frames", fm_q.size(), 3);
    if (fm_q.size() >= 3) begin
      check(fm_q[0] == 2720, "R4 marker on M1 with lead 0", fm_q[0], 2720);
      check(fm_q[1] - fm_q[0] == 4760, "R2 marker spacing", fm_q[1] - fm_q[0], 4760);
      check(fm_q[1] == 7480, "R8 mid-frame lead change deferred", fm_q[1], 7480);
      check(fm_q[2] == 12040, "R5 marker with lead 200", fm_q[2], 12040);
    end

    sync_on = 1'b0;
    nq = fm_q.size();
    wait_rel(23000);
    check(fm_q.size() == nq, "R6 no marker while disabled", fm_q.size(), nq);

    sync_on = 1'b1;
    wait_rel(23100);
    pulse_load(l1);
    wait_rel(l1 + 2600);
    check(fm_q[$] == l1 + 2520, "R7 marker after frame load", fm_q[$] - l1, 2520);

    sync_lead = 8'd255;
    wait_rel(l1 + 3000);
    pulse_load(l2);
    wait_rel(l2 + 2600);
    check(fm_q[$] == l2 + 2465, "R5 marker with lead 255", fm_q[$] - l2, 2465);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule